// File: doc/BRIEF.md
# Debug Register Access Injection Sequencer

This block moves a value into or out of a core register of a halted processor. It does this by feeding instruction frames into the processor's pipeline through the debug instruction scan chain. A request gives a register number, a direction, a write value and an instruction-set mode bit. The mode bit selects either the wide 32-bit instruction set or the compact 16-bit one. The sequencer then emits a fixed series of frames to an external JTAG shifter. Each frame is one speed/breakpoint bit plus a 32-bit word, and the shifter pushes each frame into the pipeline by passing through Run-Test/Idle. On a read, the sequencer keeps the word that the shifter returns in the slot where the stored register value appears on the data bus.

The frames are built from three primitives:
- A store primitive reads a register.
- A load primitive writes a register.
- A move primitive copies between a high register and r0 in compact mode.

Each primitive is padded with no-ops so that the useful instruction reaches the execute stage at the right moment. A program-counter write needs two extra refill no-ops. In compact mode a high register can only be reached through r0, so r0 is saved first and restored last. One response pulse ends every request.

Top module: `dbginj_seq`

## Requirements
- R1: A frame is offered with `frm_valid` and is complete on the cycle when `frm_ready` is high. While the frame waits, `frm_word` stays stable. The next frame is offered only after completion, and no frame is offered while `req_ready` is high.
- R2: Every frame has `frm_sysspd` = 0.
- R3: A read of a direct register takes 6 frames: NOP, store, NOP, NOP, NOP, NOP. `rsp_rdata` is the `frm_rdata` returned with the sixth frame. `rsp_valid` is high for exactly one cycle. A write returns `rsp_rdata` = 0.
- R4: A write of a direct register takes two passes, first with data 0 and then with `req_wdata`. Each pass is NOP, load, NOP, NOP, data word, NOP, NOP.
- R5: In wide mode, a write to register 15 inserts two more NOPs after the data word in each pass, so each pass is 9 frames.
- R6: The no-op word is 0xE1A00000 in wide mode (`req_compact`=0). In compact mode it is 0x46C046C0, which is the halfword 0x46C0 in both halves.
- R7: Wide store is 0xE58E0000 | reg<<12 and wide load is 0xE59E0000 | reg<<12, using reg bits 3:0. For compact registers 0..7, the store is halfword 0x6000|reg and the load is halfword 0x6800|reg, each placed in both halves.
- R8: A compact read of register 8..15 runs four steps:
  1. Read r0 and keep the word as the saved value.
  2. Move NOP, 0x4640|(reg&7)<<3, NOP, NOP, NOP.
  3. Read r0 again; this word is the result.
  4. Write r0 with the saved value in one pass.
- R9: A compact write of register 8..15 runs these steps:
  1. Save r0 with a read.
  2. Write r0 with 0, then with `req_wdata`.
  3. Move with 0x4680|(reg&7).
  4. Restore r0 with the saved value in one pass.
- R10: A compact request with a register number above 15 issues no frame and answers with `rsp_valid` and `rsp_err` both high. Every other request answers with `rsp_err` low.
- R11: During and right after reset, `req_ready`=1, `frm_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write register, 0 = read |
| req_compact | input | 1 | Instruction-set mode bit, 1 = compact 16-bit |
| req_reg | input | REG_W | Register number |
| req_wdata | input | WORD_W | Value to write |
| frm_valid | output | 1 | Frame offered to the shifter |
| frm_ready | input | 1 | Shifter has finished the offered frame |
| frm_sysspd | output | 1 | Speed/breakpoint bit of the frame |
| frm_word | output | WORD_W | Instruction or data word of the frame |
| frm_rdata | input | WORD_W | Word shifted out while the frame went in |
| rsp_valid | output | 1 | One-cycle end-of-request pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | WORD_W | Register value for reads |

## Verification
The checker assumes that `req_valid` is raised only while `req_ready` is high. It also assumes that the shifter raises `frm_ready` only while a frame is offered and for a single cycle per frame. The bench keeps to both assumptions:
- Its driver issues one request, then waits for the response before issuing the next.
- Its shifter model answers each offered frame once, after a random delay of zero to two cycles, and returns a word that depends only on the frame's position in the run.

Because the returned word depends only on position, the expected result and the saved r0 value can be predicted without any knowledge of the design.

// File: rtl/dbginj_pkg.sv
package dbginj_pkg;

   // Kind of pipeline primitive driven by one planning step
   typedef enum logic [1:0] {PK_RD, PK_WR, PK_SWAP} prim_kind_t;
   // Source of the data word in a load primitive
   typedef enum logic [1:0] {DS_ZERO, DS_VAL, DS_SAVED} dsel_t;
   // Where a returned word is kept
   typedef enum logic [1:0] {CP_NONE, CP_SAVE, CP_RESULT} cap_t;
   // Kind of a single frame
   typedef enum logic [1:0] {FK_NOP, FK_INSTR, FK_DATA} fkind_t;
   // Sequencer state
   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP} seq_state_t;

   typedef struct packed {
      prim_kind_t kind;
      dsel_t      dsel;
      cap_t       cap;
      logic       is_pc;
      logic       last;
   } prim_t;

   // Frame counts of each primitive
   localparam int RD_LEN    = 6;
   localparam int SWAP_LEN  = 5;
   localparam int WR_LEN    = 7;
   localparam int PC_REFILL = 2;
   // Slot positions inside a primitive
   localparam int INSTR_SLOT = 1;
   localparam int DATA_SLOT  = 4;
   localparam int CAP_SLOT   = RD_LEN - 1;

endpackage

// File: rtl/dbginj_plan.sv
module dbginj_plan
   import dbginj_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter int          STEP_W      = 3,
   parameter bit          DUP_HALF    = 1'b1,
   parameter logic [31:0] NOP_WIDE    = 32'hE1A0_0000,
   parameter logic [15:0] NOP_COMPACT = 16'h46C0
) (
   input  logic              op_write,
   input  logic              op_compact,
   input  logic [3:0]        op_reg,
   input  logic [STEP_W-1:0] step,
   output prim_t             prim,
   output logic [WORD_W-1:0] instr,
   output logic [WORD_W-1:0] nop_word
);

   localparam logic [31:0] W_STR_BASE = 32'hE58E_0000;
   localparam logic [31:0] W_LDR_BASE = 32'hE59E_0000;
   localparam logic [15:0] C_STR_BASE = 16'h6000;
   localparam logic [15:0] C_LDR_BASE = 16'h6800;
   localparam logic [15:0] C_MOV_TOLO = 16'h4640;
   localparam logic [15:0] C_MOV_TOHI = 16'h4680;
   localparam int          N_HALF     = 7;

   if (WORD_W != 32) begin : g_bad_word
      $error("dbginj_plan: WORD_W must be 32");
   end
   if (STEP_W < 3) begin : g_bad_step
      $error("dbginj_plan: STEP_W must hold five steps");
   end

   logic [2:0]  rl;
   logic        hi;
   logic [31:0] w_str, w_ldr;
   logic [15:0] half [N_HALF];
   logic [31:0] full [N_HALF];

   assign rl = op_reg[2:0];
   assign hi = op_compact & op_reg[3];

   assign w_str = W_STR_BASE | {16'h0, op_reg, 12'h000};
   assign w_ldr = W_LDR_BASE | {16'h0, op_reg, 12'h000};

   // compact halfwords: 0 str rl, 1 ldr rl, 2 str r0, 3 ldr r0, 4 mov r0<-Rh, 5 mov Rh<-r0, 6 nop
   assign half[0] = C_STR_BASE | {13'h0, rl};
   assign half[1] = C_LDR_BASE | {13'h0, rl};
   assign half[2] = C_STR_BASE;
   assign half[3] = C_LDR_BASE;
   assign half[4] = C_MOV_TOLO | {10'h0, rl, 3'h0};
   assign half[5] = C_MOV_TOHI | {13'h0, rl};
   assign half[6] = NOP_COMPACT;

   // Expansion of a compact halfword into a chain word
   for (genvar i = 0; i < N_HALF; i++) begin : g_exp
      if (DUP_HALF) begin : g_dup
         assign full[i] = {half[i], half[i]};
      end else begin : g_zx
         assign full[i] = {16'h0000, half[i]};
      end
   end

   assign nop_word = op_compact ? full[6] : NOP_WIDE;

   always_comb begin
      prim  = '{kind: PK_RD, dsel: DS_ZERO, cap: CP_RESULT, is_pc: 1'b0, last: 1'b1};
      instr = '0;
      if (!op_compact) begin
         if (!op_write) begin
            instr = w_str;
         end else begin
            instr      = w_ldr;
            prim.kind  = PK_WR;
            prim.cap   = CP_NONE;
            prim.is_pc = (op_reg == 4'd15);
            prim.dsel  = (step == '0) ? DS_ZERO : DS_VAL;
            prim.last  = (step != '0);
         end
      end else if (!hi) begin
         if (!op_write) begin
            instr = full[0];
         end else begin
            instr     = full[1];
            prim.kind = PK_WR;
            prim.cap  = CP_NONE;
            prim.dsel = (step == '0) ? DS_ZERO : DS_VAL;
            prim.last = (step != '0);
         end
      end else if (!op_write) begin
         case (step)
            3'd0: begin
               instr = full[2]; prim.cap = CP_SAVE; prim.last = 1'b0;
            end
            3'd1: begin
               instr = full[4]; prim.kind = PK_SWAP; prim.cap = CP_NONE; prim.last = 1'b0;
            end
            3'd2: begin
               instr = full[2]; prim.last = 1'b0;
            end
            default: begin
               instr = full[3]; prim.kind = PK_WR; prim.cap = CP_NONE; prim.dsel = DS_SAVED;
            end
         endcase
      end else begin
         case (step)
            3'd0: begin
               instr = full[2]; prim.cap = CP_SAVE; prim.last = 1'b0;
            end
            3'd1: begin
               instr = full[3]; prim.kind = PK_WR; prim.cap = CP_NONE; prim.last = 1'b0;
            end
            3'd2: begin
               instr = full[3]; prim.kind = PK_WR; prim.cap = CP_NONE;
               prim.dsel = DS_VAL; prim.last = 1'b0;
            end
            3'd3: begin
               instr = full[5]; prim.kind = PK_SWAP; prim.cap = CP_NONE; prim.last = 1'b0;
            end
            default: begin
               instr = full[3]; prim.kind = PK_WR; prim.cap = CP_NONE; prim.dsel = DS_SAVED;
            end
         endcase
      end
   end

endmodule

// File: rtl/dbginj_slot.sv
module dbginj_slot
   import dbginj_pkg::*;
#(
   parameter int SLOT_W = 4
) (
   input  prim_kind_t        kind,
   input  logic              is_pc,
   input  logic [SLOT_W-1:0] slot,
   output fkind_t            fk,
   output logic              cap_here,
   output logic              slot_last
);

   localparam int MAX_LEN = WR_LEN + PC_REFILL;

   if ((1 << SLOT_W) < MAX_LEN) begin : g_bad_slot
      $error("dbginj_slot: SLOT_W too narrow");
   end

   logic [SLOT_W-1:0] len_m1;

   always_comb begin
      unique case (kind)
         PK_RD:   len_m1 = SLOT_W'(RD_LEN - 1);
         PK_SWAP: len_m1 = SLOT_W'(SWAP_LEN - 1);
         default: len_m1 = is_pc ? SLOT_W'(MAX_LEN - 1) : SLOT_W'(WR_LEN - 1);
      endcase
   end

   always_comb begin
      if (slot == SLOT_W'(INSTR_SLOT))
         fk = FK_INSTR;
      else if (kind == PK_WR && slot == SLOT_W'(DATA_SLOT))
         fk = FK_DATA;
      else
         fk = FK_NOP;
   end

   assign cap_here  = (kind == PK_RD) && (slot == SLOT_W'(CAP_SLOT));
   assign slot_last = (slot == len_m1);

endmodule

// File: rtl/dbginj_seq.sv
module dbginj_seq
   import dbginj_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter int          REG_W       = 5,
   parameter bit          DUP_HALF    = 1'b1,
   parameter logic [31:0] NOP_WIDE    = 32'hE1A0_0000,
   parameter logic [15:0] NOP_COMPACT = 16'h46C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_compact,
   input  logic [REG_W-1:0]  req_reg,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              frm_valid,
   input  logic              frm_ready,
   output logic              frm_sysspd,
   output logic [WORD_W-1:0] frm_word,
   input  logic [WORD_W-1:0] frm_rdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [WORD_W-1:0] rsp_rdata
);

   localparam int STEP_W = 3;
   localparam int SLOT_W = 4;

   if (REG_W < 5) begin : g_bad_reg
      $error("dbginj_seq: REG_W must be at least 5");
   end

   seq_state_t        state_q;
   logic              op_write_q, op_compact_q, err_q;
   logic [3:0]        op_reg_q;
   logic [WORD_W-1:0] wdata_q, saved_q, result_q;
   logic [STEP_W-1:0] step_q;
   logic [SLOT_W-1:0] slot_q;

   prim_t             prim;
   logic [WORD_W-1:0] instr, nop_word, data_word;
   fkind_t            fk;
   logic              cap_here, slot_last, over_range;

   dbginj_plan #(
      .WORD_W(WORD_W), .STEP_W(STEP_W), .DUP_HALF(DUP_HALF),
      .NOP_WIDE(NOP_WIDE), .NOP_COMPACT(NOP_COMPACT)
   ) u_plan (
      .op_write(op_write_q), .op_compact(op_compact_q), .op_reg(op_reg_q),
      .step(step_q), .prim(prim), .instr(instr), .nop_word(nop_word)
   );

   dbginj_slot #(.SLOT_W(SLOT_W)) u_slot (
      .kind(prim.kind), .is_pc(prim.is_pc), .slot(slot_q),
      .fk(fk), .cap_here(cap_here), .slot_last(slot_last)
   );

   assign over_range = |req_reg[REG_W-1:4];

   always_comb begin
      unique case (prim.dsel)
         DS_VAL:   data_word = wdata_q;
         DS_SAVED: data_word = saved_q;
         default:  data_word = '0;
      endcase
   end

   always_comb begin
      unique case (fk)
         FK_INSTR: frm_word = instr;
         FK_DATA:  frm_word = data_word;
         default:  frm_word = nop_word;
      endcase
   end

   assign frm_valid  = (state_q == ST_RUN);
   assign frm_sysspd = 1'b0;
   assign req_ready  = (state_q == ST_IDLE);
   assign rsp_valid  = (state_q == ST_RESP);
   assign rsp_err    = rsp_valid & err_q;
   assign rsp_rdata  = result_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         op_write_q   <= 1'b0;
         op_compact_q <= 1'b0;
         op_reg_q     <= '0;
         wdata_q      <= '0;
         saved_q      <= '0;
         result_q     <= '0;
         err_q        <= 1'b0;
         step_q       <= '0;
         slot_q       <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  op_write_q   <= req_write;
                  op_compact_q <= req_compact;
                  op_reg_q     <= req_reg[3:0];
                  wdata_q      <= req_wdata;
                  result_q     <= '0;
                  step_q       <= '0;
                  slot_q       <= '0;
                  err_q        <= req_compact & over_range;
                  state_q      <= (req_compact & over_range) ? ST_RESP : ST_RUN;
               end
            end
            ST_RUN: begin
               if (frm_ready) begin
                  if (cap_here && prim.cap == CP_SAVE)   saved_q  <= frm_rdata;
                  if (cap_here && prim.cap == CP_RESULT) result_q <= frm_rdata;
                  if (slot_last) begin
                     slot_q <= '0;
                     if (prim.last) state_q <= ST_RESP;
                     else           step_q  <= step_q + 1'b1;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dbginj_seq_chk.sv
module dbginj_seq_chk #(
   parameter int WORD_W = 32,
   parameter int REG_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_compact,
   input logic [REG_W-1:0]  req_reg,
   input logic              frm_valid,
   input logic              frm_ready,
   input logic [WORD_W-1:0] frm_word,
   input logic              rsp_valid,
   input logic              rsp_err
);

   logic       bad_q;
   logic [7:0] nfr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_q <= 1'b0;
         nfr_q <= '0;
      end else if (req_valid && req_ready) begin
         bad_q <= req_compact & (|req_reg[REG_W-1:4]);
         nfr_q <= '0;
      end else if (frm_valid && frm_ready && nfr_q != 8'hFF) begin
         nfr_q <= nfr_q + 8'd1;
      end
   end

   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_ready |=> frm_valid && $stable(frm_word)); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !frm_valid); // R1
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3
   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> nfr_q == 8'd0); // R10
   AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_err == bad_q); // R10

endmodule

bind dbginj_seq dbginj_seq_chk #(.WORD_W(WORD_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_compact(req_compact), .req_reg(req_reg), .frm_valid(frm_valid),
   .frm_ready(frm_ready), .frm_word(frm_word), .rsp_valid(rsp_valid),
   .rsp_err(rsp_err)
);

// File: tb/sim_dbginj_seq.sv
`timescale 1ns/1ps
module sim_dbginj_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_write, req_compact;
   logic [4:0]  req_reg;
   logic [31:0] req_wdata;
   logic        frm_valid, frm_ready, frm_sysspd;
   logic [31:0] frm_word, frm_rdata;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int          total = 0;
   int          bad   = 0;
   int          gidx  = 0;   // frames completed by the shifter model
   int          pidx  = 0;   // frames predicted by the driver
   logic [31:0] exp_q [$];
   string       cur_tag = "R1";

   always #5 clk = ~clk;

   dbginj_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_compact(req_compact), .req_reg(req_reg),
      .req_wdata(req_wdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
      .frm_sysspd(frm_sysspd), .frm_word(frm_word), .frm_rdata(frm_rdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_of(input int k);
      return 32'hC0DE_0000 + 32'(k);
   endfunction

   function automatic logic [31:0] cx(input logic [15:0] h);
      return {h, h};
   endfunction

   function automatic logic [31:0] nopw(input bit c);   // R6
      return c ? cx(16'h46C0) : 32'hE1A0_0000;
   endfunction

   task automatic push(input logic [31:0] w);
      exp_q.push_back(w);
      pidx++;
   endtask

   task automatic push_rd(input bit c, input logic [31:0] w, output logic [31:0] cap);
      push(nopw(c)); push(w);
      push(nopw(c)); push(nopw(c)); push(nopw(c));
      cap = rd_of(pidx);
      push(nopw(c));
   endtask

   task automatic push_wr(input bit c, input logic [31:0] w, input logic [31:0] d, input bit pc);
      push(nopw(c)); push(w); push(nopw(c)); push(nopw(c)); push(d);
      if (pc) begin push(nopw(c)); push(nopw(c)); end
      push(nopw(c)); push(nopw(c));
   endtask

   task automatic push_swap(input bit c, input logic [31:0] w);
      push(nopw(c)); push(w); push(nopw(c)); push(nopw(c)); push(nopw(c));
   endtask

   // Shifter model and monitor: compare each offered frame with the queue
   initial begin
      frm_ready = 1'b0;
      frm_rdata = '0;
      forever begin
         @(negedge clk);
         frm_ready = 1'b0;
         if (rst_n && frm_valid) begin
            logic [31:0] first_w;
            logic [31:0] ew;
            int dly;
            first_w = frm_word;
            dly = $urandom_range(0, 2);
            repeat (dly) @(negedge clk);
            chk(frm_word == first_w, "R1 frame word held while waiting", frm_word, first_w);
            chk(frm_sysspd == 1'b0, "R2 speed bit", 32'(frm_sysspd), 32'h0);
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected frame"}, frm_word, 32'h0);
            end else begin
               ew = exp_q.pop_front();
               chk(frm_word == ew, {cur_tag, " frame word"}, frm_word, ew);
            end
            frm_rdata = rd_of(gidx);
            gidx++;
            frm_ready = 1'b1;
         end
      end
   end

   task automatic run_op(input bit wr, input bit c, input logic [4:0] r,
                         input logic [31:0] wd, input string tag);
      logic [31:0] exp_res, saved, dummy;
      bit          exp_err;
      int          n;
      exp_res = '0;
      exp_err = 1'b0;
      cur_tag = tag;
      if (c && r > 5'd15) begin
         exp_err = 1'b1;
      end else if (!c) begin
         if (!wr) begin
            push_rd(1'b0, 32'hE58E_0000 | (32'(r[3:0]) << 12), exp_res);
         end else begin
            push_wr(1'b0, 32'hE59E_0000 | (32'(r[3:0]) << 12), 32'h0, r[3:0] == 4'd15);
            push_wr(1'b0, 32'hE59E_0000 | (32'(r[3:0]) << 12), wd, r[3:0] == 4'd15);
         end
      end else if (r < 5'd8) begin
         if (!wr) begin
            push_rd(1'b1, cx(16'h6000 | 16'(r[2:0])), exp_res);
         end else begin
            push_wr(1'b1, cx(16'h6800 | 16'(r[2:0])), 32'h0, 1'b0);
            push_wr(1'b1, cx(16'h6800 | 16'(r[2:0])), wd, 1'b0);
         end
      end else if (!wr) begin
         push_rd(1'b1, cx(16'h6000), saved);
         push_swap(1'b1, cx(16'h4640 | (16'(r[2:0]) << 3)));
         push_rd(1'b1, cx(16'h6000), exp_res);
         push_wr(1'b1, cx(16'h6800), saved, 1'b0);
      end else begin
         push_rd(1'b1, cx(16'h6000), saved);
         push_wr(1'b1, cx(16'h6800), 32'h0, 1'b0);
         push_wr(1'b1, cx(16'h6800), wd, 1'b0);
         push_swap(1'b1, cx(16'h4680 | 16'(r[2:0])));
         push_wr(1'b1, cx(16'h6800), saved, 1'b0);
         dummy = saved;
      end
      chk(req_ready == 1'b1, {tag, " idle before request"}, 32'(req_ready), 32'h1);
      req_write   = wr;
      req_compact = c;
      req_reg     = r;
      req_wdata   = wd;
      req_valid   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(rsp_valid == 1'b1, {tag, " response seen"}, 32'(rsp_valid), 32'h1);
      chk(rsp_err == exp_err, {tag, " R10 error flag"}, 32'(rsp_err), 32'(exp_err));
      chk(rsp_rdata == exp_res, {tag, " R3 response data"}, rsp_rdata, exp_res);
      chk(exp_q.size() == 0, {tag, " all frames issued"}, 32'(exp_q.size()), 32'h0);
      chk(pidx == gidx, {tag, " frame count"}, 32'(gidx), 32'(pidx));
      @(negedge clk);
      chk(rsp_valid == 1'b0, {tag, " R3 single response cycle"}, 32'(rsp_valid), 32'h0);
   endtask

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_compact = 1'b0;
      req_reg = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(req_ready == 1'b1, "R11 ready in reset", 32'(req_ready), 32'h1);
      chk(frm_valid == 1'b0, "R11 no frame in reset", 32'(frm_valid), 32'h0);
      chk(rsp_valid == 1'b0, "R11 no response in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(frm_valid == 1'b0, "R11 no frame after reset", 32'(frm_valid), 32'h0);

      run_op(1'b0, 1'b0, 5'd3,  32'h0,          "R3 R6 R7 wide read r3");
      run_op(1'b0, 1'b0, 5'd15, 32'h0,          "R3 wide read r15");
      run_op(1'b1, 1'b0, 5'd5,  32'h1234_5678,  "R4 R7 wide write r5");
      run_op(1'b1, 1'b0, 5'd15, 32'h0000_8000,  "R5 wide write pc");
      run_op(1'b0, 1'b1, 5'd2,  32'h0,          "R3 R6 R7 compact read r2");
      run_op(1'b1, 1'b1, 5'd7,  32'hDEAD_BEEF,  "R4 R7 compact write r7");
      run_op(1'b0, 1'b1, 5'd12, 32'h0,          "R8 compact read r12");
      run_op(1'b1, 1'b1, 5'd9,  32'hA5A5_0F0F,  "R9 compact write r9");
      run_op(1'b0, 1'b1, 5'd20, 32'h0,          "R10 compact reg 20 rejected");
      run_op(1'b1, 1'b1, 5'd31, 32'hFFFF_FFFF,  "R10 compact reg 31 rejected");
      run_op(1'b1, 1'b1, 5'd15, 32'h0BAD_F00D,  "R9 compact write r15");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=0", gidx);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule